// File: doc/BRIEF.md
# Multi-Master Two-Wire Bus Master

This block drives one complete transaction on a shared two-wire serial bus. The transaction carries one byte to or from a single target. On a command it waits until the bus is free. It then produces a start condition and shifts out a 7-bit target address, most significant bit first, followed by a direction bit. After the acknowledge slot it either writes one data byte or reads one data byte, and it closes the transaction with a stop condition. Both lines are open-drain: the block only asserts drive-low enables and reads back the resolved line levels.

Other masters may share the bus. The block watches the lines for start and stop conditions to tell whether the bus is busy. While the clock line is high and the block believes it is sending a 1, it compares the data line against that value on every system clock. A low reading means another master has won. The block then lets go of both lines on the next clock and reports the loss. A quarter-bit divider sets the serial rate.

Top module: `twi_bus_master`

## Requirements
- R1: After reset, both drive-low enables (`scl_oe`, `sda_oe`) are 0, `done`, `nack`, `arb_lost` and `busy` are 0, and `cmd_ready` is 1.
- R2: A command accepted while the bus is busy (a start seen on the lines with no stop after it) produces no drive on either line until a stop is seen. After that stop the transaction begins with a start condition.
- R3: The first byte on the bus is the 7-bit address, MSB first, followed by the direction bit (1 = read, 0 = write).
- R4: On a write with both bytes acknowledged, the data byte appears on the bus MSB first. `done` then rises with `nack` at 0, and `done` and `arb_lost` are never both 1.
- R5: If the address slot is not acknowledged (data line high), `nack` is set, no data byte is transferred, and a stop follows.
- R6: If the write data byte is not acknowledged, `nack` is set and the transaction ends with `done`.
- R7: On a read the block releases the data line for 8 bits and presents the received byte on `rd_data` (first bit received = bit 7). In the acknowledge slot it drives the data line low when `cmd_last` was 0 and leaves it high when `cmd_last` was 1.
- R8: If the data line reads 0 at any system clock while the clock line is high and the block is sending a 1, `arb_lost` is set. On the next clock both `scl_oe` and `sda_oe` are 0 and the block issues no stop.
- R9: `arb_lost` stays 1 until the next command is accepted, and it clears on that acceptance.
- R10: Each serial clock high phase of a data bit lasts exactly 2 × `quarter_div` system clocks, and so does each low phase (for `quarter_div` ≥ 1).
- R11: The data line changes only while the clock line is low, except for exactly one start condition and one stop condition per completed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_div | input | DIV_W | System clocks per quarter bit period |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and accepts a command |
| cmd_addr | input | 7 | Target address |
| cmd_read | input | 1 | Direction: 1 read, 0 write |
| cmd_wdata | input | 8 | Byte to write |
| cmd_last | input | 1 | On read, answer with not-acknowledge |
| rd_data | output | 8 | Byte received on a read |
| busy | output | 1 | Bus is busy (start seen, stop not yet seen) |
| done | output | 1 | Transaction finished with a stop |
| nack | output | 1 | An acknowledge slot read high |
| arb_lost | output | 1 | Arbitration was lost |
| scl_oe | output | 1 | Pull clock line low |
| scl_in | input | 1 | Sampled clock line |
| sda_oe | output | 1 | Pull data line low |
| sda_in | input | 1 | Sampled data line |

## Verification
A wrong bit counter or byte flag shows up at the target model within one frame: as a shifted address, a data byte on the wrong byte, or an acknowledge driven in the wrong slot. A wrong data-line update instant shows up at once as an extra start or stop. A bad arbitration comparator only shows up when a competing master pulls the line in the middle of a high phase. So the bench injects that pull several clocks after the rising edge and expects both lines released on the next clock. A divider error shows up in the measured length of the first high phase.

// File: rtl/twi_bus_master.sv
module twi_bus_master #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_addr,
  input  logic             cmd_read,
  input  logic [7:0]       cmd_wdata,
  input  logic             cmd_last,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             nack,
  output logic             arb_lost,
  output logic             scl_oe,
  input  logic             scl_in,
  output logic             sda_oe,
  input  logic             sda_in
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_BIT, S_STOP, S_FIN} st_t;

  st_t             state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cnt_nx;
  logic [1:0]      qph;
  logic [3:0]      bitn;
  logic            second, rd_r, last_r, sda_low;
  logic [7:0]      shreg, wdata_r, rdata_r;
  logic            prev_scl, prev_sda, busy_r, done_r, nack_r, arb_r;
  logic            tick, receiving, mack_slot, owns_bit, drive_low, lose;
  logic            start_det, stop_det;

  assign cnt_nx    = {1'b0, cnt} + 1'b1;
  assign tick      = (state != S_IDLE) && (state != S_WAIT) && (cnt_nx >= {1'b0, quarter_div});
  assign receiving = second && rd_r && (bitn < 4'd8);
  assign mack_slot = second && rd_r && (bitn == 4'd8);
  assign owns_bit  = ((bitn < 4'd8) && !receiving) || mack_slot;
  assign drive_low = ((bitn < 4'd8) && !receiving) ? !shreg[7] : (mack_slot && !last_r);
  assign lose      = (state == S_BIT) && qph[1] && owns_bit && !sda_low && scl_in && !sda_in;

  assign start_det = prev_scl && scl_in && prev_sda && !sda_in;
  assign stop_det  = prev_scl && scl_in && !prev_sda && sda_in;

  assign scl_oe    = ((state == S_BIT) || (state == S_STOP)) && !qph[1];
  assign sda_oe    = sda_low;
  assign cmd_ready = (state == S_IDLE);
  assign busy      = busy_r;
  assign done      = done_r;
  assign nack      = nack_r;
  assign arb_lost  = arb_r;
  assign rd_data   = rdata_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; qph <= '0; bitn <= '0; second <= 1'b0;
      rd_r <= 1'b0; last_r <= 1'b0; sda_low <= 1'b0; shreg <= '0; wdata_r <= '0;
      rdata_r <= '0; prev_scl <= 1'b1; prev_sda <= 1'b1; busy_r <= 1'b0;
      done_r <= 1'b0; nack_r <= 1'b0; arb_r <= 1'b0;
    end else begin
      prev_scl <= scl_in;
      prev_sda <= sda_in;
      if (start_det) busy_r <= 1'b1;
      else if (stop_det) busy_r <= 1'b0;

      if (lose) begin
        state <= S_IDLE; arb_r <= 1'b1; sda_low <= 1'b0; cnt <= '0; qph <= '0;
      end else begin
        case (state)
          S_IDLE: if (cmd_valid) begin
            shreg <= {cmd_addr, cmd_read}; rd_r <= cmd_read; last_r <= cmd_last;
            wdata_r <= cmd_wdata; done_r <= 1'b0; nack_r <= 1'b0; arb_r <= 1'b0;
            cnt <= '0; qph <= '0; state <= S_WAIT;
          end
          S_WAIT: if (!busy_r && !start_det) state <= S_START;
          default: if (!tick) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            qph <= qph + 2'd1;
            case (state)
              S_START: begin
                if (qph == 2'd1) sda_low <= 1'b1;
                if (qph == 2'd3) begin state <= S_BIT; bitn <= '0; second <= 1'b0; end
              end
              S_BIT: begin
                if (qph == 2'd0) sda_low <= drive_low;
                if (qph == 2'd3) begin
                  if (bitn < 4'd8) begin
                    shreg <= {shreg[6:0], receiving ? sda_in : 1'b0};
                    if (receiving && bitn == 4'd7) rdata_r <= {shreg[6:0], sda_in};
                    bitn <= bitn + 4'd1;
                  end else if (mack_slot) begin
                    state <= S_STOP;
                  end else if (sda_in) begin
                    nack_r <= 1'b1; state <= S_STOP;
                  end else if (!second) begin
                    second <= 1'b1; bitn <= '0; shreg <= rd_r ? 8'h00 : wdata_r;
                  end else begin
                    state <= S_STOP;
                  end
                end
              end
              S_STOP: begin
                if (qph == 2'd0) sda_low <= 1'b1;
                if (qph == 2'd3) begin state <= S_FIN; sda_low <= 1'b0; end
              end
              S_FIN: if (qph == 2'd3) begin state <= S_IDLE; done_r <= 1'b1; end
              default: state <= S_IDLE;
            endcase
          end
        endcase
      end
    end
  end

  AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    lose |=> (!scl_oe && !sda_oe && arb_lost)); // R8
  AST_SDA_MOVES_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BIT && sda_low != $past(sda_low)) |-> (scl_oe && $past(scl_oe))); // R11
  AST_START_ON_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && $past(state) == S_WAIT) |-> !$past(busy_r)); // R2
  AST_ARB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !(cmd_valid && cmd_ready)) |=> arb_lost); // R9
  AST_DONE_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && arb_lost)); // R4

endmodule

// File: tb/tb_twi_bus_master.sv
module tb_twi_bus_master;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 0, rst_n = 0;
  logic [15:0] quarter_div = 16'd2;
  logic cmd_valid = 0, cmd_read = 0, cmd_last = 0;
  logic [6:0] cmd_addr = 0;
  logic [7:0] cmd_wdata = 0;
  logic cmd_ready, busy, done, nack, arb_lost, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic sl_pull = 0, oth_sda = 0, oth_scl = 0;
  wire scl_line = !(scl_oe | oth_scl);
  wire sda_line = !(sda_oe | sl_pull | oth_sda);

  twi_bus_master dut (.clk(clk), .rst_n(rst_n), .quarter_div(quarter_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
    .cmd_wdata(cmd_wdata), .cmd_last(cmd_last), .rd_data(rd_data), .busy(busy), .done(done),
    .nack(nack), .arb_lost(arb_lost), .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe),
    .sda_in(sda_line));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int n_start = 0, n_stop = 0, bitn = -100, m_ack_seen = 0;
  logic [7:0] a_sh = 0, d_sh = 0, rd_byte = 0;
  logic m_ack = 0, ack_data = 1;
  time t_rise = 0, high_ns = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge sda_line) if (scl_line === 1'b1) begin n_start++; bitn = -1; sl_pull = 0; end
  always @(posedge sda_line) if (scl_line === 1'b1) n_stop++;

  always @(posedge scl_line) if (bitn >= 0) begin
    if (bitn == 0) t_rise = $time;
    if (bitn / 9 == 0 && bitn % 9 < 8) a_sh = {a_sh[6:0], sda_line};
    if (bitn / 9 == 1 && bitn % 9 < 8 && !a_sh[0]) d_sh = {d_sh[6:0], sda_line};
    if (bitn / 9 == 1 && bitn % 9 == 8 && a_sh[0]) begin m_ack = !sda_line; m_ack_seen = 1; end
  end

  always @(negedge scl_line) if (bitn >= -1) begin
    if (bitn == 0) high_ns = $time - t_rise;
    bitn++;
    if (bitn / 9 == 0 && bitn % 9 == 8) sl_pull = (a_sh[7:1] == SLV);
    else if (bitn / 9 == 1 && bitn % 9 < 8 && a_sh[0] && a_sh[7:1] == SLV)
      sl_pull = !rd_byte[7 - bitn % 9];
    else if (bitn / 9 == 1 && bitn % 9 == 8 && !a_sh[0]) sl_pull = (a_sh[7:1] == SLV) && ack_data;
    else sl_pull = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  function automatic bit exp_nack(input logic [6:0] a, input bit rd, input bit ackd);
    return (a != SLV) || (!rd && !ackd);
  endfunction

  task automatic issue(input logic [6:0] a, input bit rd, input logic [7:0] wd, input bit last);
    @(negedge clk);
    cmd_addr = a; cmd_read = rd; cmd_wdata = wd; cmd_last = last; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000 && !(done || arb_lost); i++) @(negedge clk);
  endtask

  task automatic xfer(input logic [6:0] a, input bit rd, input logic [7:0] wd, input bit last,
                      input int div, input bit ackd);
    bit en;
    quarter_div = 16'(div); ack_data = ackd; rd_byte = 8'($urandom);
    n_start = 0; n_stop = 0; m_ack_seen = 0; a_sh = 0; d_sh = 0; high_ns = 0;
    en = exp_nack(a, rd, ackd);
    issue(a, rd, wd, last);
    wait_end();
    chk(done == 1 && arb_lost == 0, "R4 done", done, 1);
    chk(a_sh == {a, rd}, "R3 address byte", a_sh, {a, rd});
    if (a != SLV) chk(nack == 1, "R5 address nack", nack, 1);
    else if (!rd) chk(nack == en, "R6 data ack", nack, en);
    else chk(nack == 0, "R7 read nack flag", nack, 0);
    if (a == SLV && !rd) chk(d_sh == wd, "R4 write data", d_sh, wd);
    if (a == SLV && rd) begin
      chk(rd_data == rd_byte, "R7 read data", rd_data, rd_byte);
      chk(m_ack_seen == 1 && m_ack == !last, "R7 master ack", m_ack, !last);
    end
    if (a != SLV) chk(m_ack_seen == 0 && d_sh == 0, "R5 no data byte", d_sh, 0);
    chk(n_start == 1 && n_stop == 1, "R11 single start/stop", n_start * 10 + n_stop, 11);
    chk(high_ns == time'(16 * div), "R10 high phase ns", int'(high_ns), 16 * div);
    chk(scl_oe == 0 && sda_oe == 0 && busy == 0, "R4 bus released", {scl_oe, sda_oe, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk({done, nack, arb_lost, busy} == 0, "R1 status clear", {done, nack, arb_lost, busy}, 0);
    chk(cmd_ready == 1, "R1 ready", cmd_ready, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    xfer(SLV, 0, 8'hA5, 0, 1, 1);
    xfer(SLV, 0, 8'h3C, 0, 3, 0);
    xfer(7'h11, 0, 8'hFF, 0, 2, 1);
    xfer(SLV, 1, 8'h00, 0, 2, 1);
    xfer(SLV, 1, 8'h00, 1, 4, 1);
    xfer(7'h55, 1, 8'h00, 1, 1, 1);

    for (int k = 0; k < 8; k++) begin
      logic [6:0] a;
      a = ($urandom % 2) ? SLV : 7'($urandom);
      xfer(a, 1'($urandom), 8'($urandom), 1'($urandom), 1 + int'($urandom % 4), 1'($urandom));
    end

    // R8: competing master pulls data low mid-way through a high phase
    quarter_div = 16'd3;
    issue(7'h7F, 0, 8'h00, 0);
    for (int i = 0; i < 5000 && !(bitn == 1 && scl_line == 1); i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
    chk(arb_lost == 0, "R8 not lost before pull", arb_lost, 0);
    oth_sda = 1;
    @(negedge clk);
    chk(arb_lost == 1, "R8 loss flagged", arb_lost, 1);
    chk(scl_oe == 0 && sda_oe == 0, "R8 lines released", {scl_oe, sda_oe}, 0);
    chk(done == 0, "R8 no done", done, 0);
    repeat (20) @(negedge clk);
    chk(arb_lost == 1 && busy == 1, "R9 sticky while busy", {arb_lost, busy}, 3);

    // R2: new command waits for the other master's stop
    n_start = 0; n_stop = 0; a_sh = 0; d_sh = 0; ack_data = 1;
    issue(SLV, 0, 8'h96, 0);
    chk(arb_lost == 0, "R9 cleared on accept", arb_lost, 0);
    begin
      int drv = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); drv |= (scl_oe | sda_oe); end
      chk(drv == 0, "R2 held off while busy", drv, 0);
    end
    oth_sda = 0;
    wait_end();
    chk(done == 1 && nack == 0, "R2 runs after stop", {done, nack}, 2);
    chk(d_sh == 8'h96, "R2 data after wait", d_sh, 8'h96);
    chk(n_start == 1, "R2 own start", n_start, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule